// File: doc/BRIEF.md
# Ticket-Ordered Hardware Queue Lock

This block arbitrates one shared lock among a set of requesters and hands it out strictly in arrival order. Each arriving requester draws a ticket from a shared counter that counts up and wraps around, and the ticket's low bits select one entry of a circular ring of slot flags. Exactly one slot flag is in the "owner" state at any time. A requester that has drawn a ticket waits until the flag of its own slot becomes owner, and only then holds the lock. No requester ever looks at any other slot.

Releasing the lock is a two-step hand-off done in one clock edge: the holder's own slot goes back to "wait", and the slot after it in the ring becomes owner. The waiter holding the next ticket then sees its flag and takes the lock. Two error pulses report misuse. One is raised when an enter request finds the ring full. The other is raised when an exit comes from a requester that does not hold the lock.

Every requester runs its own small state machine with three states. IDLE has no ticket. QUEUED holds a ticket and is waiting for its slot. OWNER holds the lock. The transitions are:
- ENTER (IDLE to QUEUED): the arbiter picks the requester and the ring has room.
- TAKE (QUEUED to OWNER): the requester's slot flag reads owner.
- LEAVE (OWNER to IDLE): an exit request arrives.

Every other input combination keeps the state.

Top module: `qlock_mgr`

## Requirements
- R1: After reset, no grant is asserted, every ticket output reads 0, both error outputs are 0, slot 0 is owner and the ticket counter is 0. A lone requester entering on an idle lock therefore receives ticket 0.
- R2: An accepted enter gives the requester the current counter value as its ticket, and the counter steps by one modulo N_SLOT. A requester's ticket output keeps its value until that requester enters again.
- R3: When several IDLE requesters assert enter in the same cycle, only the lowest-numbered one is accepted. The others stay IDLE and are served in later cycles while they keep enter asserted, so every outstanding ticket is distinct.
- R4: A QUEUED requester becomes OWNER on the first clock edge at which its slot flag reads owner. The grant output equals the OWNER state, so on a free lock the grant rises two cycles after the cycle in which enter was accepted.
- R5: An exit from the OWNER returns it to IDLE and moves the owner flag from its slot to slot (ticket+1) mod N_SLOT. The requester holding the next ticket sees its grant two cycles after the exit cycle.
- R6: At most one grant is asserted at any time, and grants are given in the order in which tickets were issued.
- R7: While N_SLOT requesters hold tickets, a pending enter is refused: no ticket is issued and the counter is unchanged. In that case overflow_err is 1 in the following cycle.
- R8: An exit from a requester that is not OWNER has no effect on grants, tickets or the owner slot, and proto_err is 1 in the following cycle.
- R9: An enter from a requester that is QUEUED or OWNER is ignored and does not change its ticket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | N_REQ | Per-requester level request to join the queue |
| exit_req | input | N_REQ | Per-requester release request |
| grant | output | N_REQ | Per-requester lock held indication |
| ticket | output | N_REQ*TW | Per-requester ticket; the field of requester i sits at bits i*TW and up |
| overflow_err | output | 1 | Pulse: an enter found the ring full |
| proto_err | output | 1 | Pulse: an exit came from a non-holder |

## Verification
The assertions assume that N_SLOT is a power of two, so the wrapping counter already equals its slot index. They also assume reset is applied before traffic starts. They do not assume that requesters behave well: enters while queued, exits from non-holders and more requesters than slots are all legal stimulus. The bench drives these on purpose and compares against a behavioural queue model every cycle. The bench keeps N_REQ larger than N_SLOT so that overflow refusals happen both under directed fill and under random traffic.

// File: rtl/qlock_pkg.sv
package qlock_pkg;
    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_QUEUED = 2'd1,
        RQ_OWNER  = 2'd2
    } rq_state_e;
endpackage

// File: rtl/qlock_arb.sv
module qlock_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);
    // lowest index has priority
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                win[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        AST_ARB_ONE_WIN: assert ($onehot0(win)); // R3
    end
endmodule

// File: rtl/qlock_slots.sv
module qlock_slots #(
    parameter int N_SLOT = 4,
    localparam int TW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              rel,
    input  logic [TW-1:0]     rel_slot,
    output logic [TW-1:0]     tail,
    output logic [N_SLOT-1:0] flags
);
    logic [TW-1:0] next_slot;

    assign next_slot = rel_slot + TW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (take) begin
            tail <= tail + TW'(1);
        end
    end

    // release: own slot back to wait first, then next slot to owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= N_SLOT'(1);
        end else if (rel) begin
            for (int i = 0; i < N_SLOT; i++) begin
                if (TW'(i) == rel_slot)  flags[i] <= 1'b0;
                if (TW'(i) == next_slot) flags[i] <= 1'b1;
            end
        end
    end

    AST_ONE_OWNER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(flags)); // R6
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tail == $past(tail) + TW'(1)); // R2
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(tail)); // R7
    AST_PASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> flags[$past(next_slot)]); // R5
endmodule

// File: rtl/qlock_req_fsm.sv
module qlock_req_fsm
    import qlock_pkg::*;
#(
    parameter int N_SLOT = 4,
    localparam int TW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic              win,
    input  logic [TW-1:0]     tail,
    input  logic [N_SLOT-1:0] flags,
    output rq_state_e         state,
    output logic [TW-1:0]     ticket,
    output logic              cand,
    output logic              rel,
    output logic              bad_exit
);
    rq_state_e state_nx;
    logic      my_flag;

    assign my_flag = flags[ticket];

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            RQ_IDLE:   if (win)      state_nx = RQ_QUEUED; // ENTER
            RQ_QUEUED: if (my_flag)  state_nx = RQ_OWNER;  // TAKE
            RQ_OWNER:  if (exit_req) state_nx = RQ_IDLE;   // LEAVE
            default:                 state_nx = RQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RQ_IDLE;
            ticket <= '0;
        end else begin
            state <= state_nx;
            if (state == RQ_IDLE && win) ticket <= tail;
        end
    end

    // outputs
    always_comb begin
        cand     = 1'b0;
        rel      = 1'b0;
        bad_exit = 1'b0;
        unique case (state)
            RQ_IDLE: begin
                cand     = enter_req;
                bad_exit = exit_req;
            end
            RQ_QUEUED: bad_exit = exit_req;
            RQ_OWNER:  rel      = exit_req;
            default:   bad_exit = exit_req;
        endcase
    end

    AST_WIN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> state == RQ_IDLE && enter_req); // R3
    AST_TICKET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        state != RQ_IDLE |=> $stable(ticket)); // R9
    AST_OWNER_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        state == RQ_OWNER |-> my_flag); // R4
    AST_TAKE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_QUEUED && my_flag) |=> state == RQ_OWNER); // R4
endmodule

// File: rtl/qlock_mgr.sv
module qlock_mgr
    import qlock_pkg::*;
#(
    parameter int N_REQ  = 6,
    parameter int N_SLOT = 4,
    localparam int TW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
    localparam int CW = $clog2(N_REQ + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  enter_req,
    input  logic [N_REQ-1:0]  exit_req,
    output logic [N_REQ-1:0]  grant,
    output logic [N_REQ*TW-1:0] ticket,
    output logic              overflow_err,
    output logic              proto_err
);
    rq_state_e       st      [N_REQ];
    logic [TW-1:0]   tk      [N_REQ];
    logic [N_REQ-1:0] cand, rel_v, bad_v, win, busy;
    logic [TW-1:0]   tail;
    logic [N_SLOT-1:0] flags;
    logic [TW-1:0]   rel_slot;
    logic [CW-1:0]   outstanding;
    logic            room, take, rel;

    always_comb begin
        outstanding = '0;
        for (int i = 0; i < N_REQ; i++) outstanding = outstanding + CW'(busy[i]);
    end

    assign room = (outstanding < CW'(N_SLOT));
    assign take = |win;
    assign rel  = |rel_v;

    always_comb begin
        rel_slot = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (rel_v[i]) rel_slot = rel_slot | tk[i];
        end
    end

    qlock_arb #(.N(N_REQ)) u_arb (
        .req (cand & {N_REQ{room}}),
        .win (win)
    );

    qlock_slots #(.N_SLOT(N_SLOT)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .rel      (rel),
        .rel_slot (rel_slot),
        .tail     (tail),
        .flags    (flags)
    );

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        qlock_req_fsm #(.N_SLOT(N_SLOT)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .enter_req (enter_req[g]),
            .exit_req  (exit_req[g]),
            .win       (win[g]),
            .tail      (tail),
            .flags     (flags),
            .state     (st[g]),
            .ticket    (tk[g]),
            .cand      (cand[g]),
            .rel       (rel_v[g]),
            .bad_exit  (bad_v[g])
        );
        assign busy[g]  = (st[g] != RQ_IDLE);
        assign grant[g] = (st[g] == RQ_OWNER);
        assign ticket[g*TW +: TW] = tk[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_err <= 1'b0;
            proto_err    <= 1'b0;
        end else begin
            overflow_err <= (|cand) && !room;
            proto_err    <= |bad_v;
        end
    end

    AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CW'(N_SLOT)); // R7
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !room |-> !take); // R7
    AST_BAD_EXIT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad_v && !rel) |=> $stable(flags)); // R8
    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_v)); // R5
endmodule

// File: tb/qlock_mgr_test.sv
module qlock_mgr_test;
    localparam int NR = 6;
    localparam int NS = 4;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0] enter_req = '0;
    logic [NR-1:0] exit_req = '0;
    logic [NR-1:0] grant;
    logic [NR*TW-1:0] ticket;
    logic overflow_err, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference: 0 idle, 1 queued, 2 owner
    int m_st[NR];
    int m_tk[NR];
    int m_tail, m_serve;
    bit m_ovf, m_pro;
    int order_q[$];

    always #2 clk = ~clk;

    qlock_mgr #(.N_REQ(NR), .N_SLOT(NS)) uut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .grant(grant), .ticket(ticket), .overflow_err(overflow_err), .proto_err(proto_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tk_of(input int i);
        return int'(ticket[i*TW +: TW]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_st[i] = 0;
            m_tk[i] = 0;
        end
        m_tail = 0; m_serve = 0; m_ovf = 0; m_pro = 0;
        order_q.delete();
    endtask

    task automatic model_step();
        int n_st[NR];
        int n_tk[NR];
        int cnt, pick, n_serve;
        bit anycand, bad;
        cnt = 0; pick = -1; anycand = 0; bad = 0; n_serve = m_serve;
        for (int i = 0; i < NR; i++) begin
            n_st[i] = m_st[i];
            n_tk[i] = m_tk[i];
            if (m_st[i] != 0) cnt++;
            if (m_st[i] == 0 && enter_req[i]) begin
                anycand = 1;
                if (pick < 0) pick = i;
            end
            if (exit_req[i] && m_st[i] != 2) bad = 1;
        end
        for (int i = 0; i < NR; i++) begin
            if (m_st[i] == 1 && m_tk[i] == m_serve) begin
                n_st[i] = 2;
                // R6: strict ticket order
                chk("R6 grant order", i, (order_q.size() > 0) ? order_q[0] : -1);
                if (order_q.size() > 0) void'(order_q.pop_front());
            end else if (m_st[i] == 2 && exit_req[i]) begin
                n_st[i] = 0;
                n_serve = (m_serve + 1) % NS;
            end
        end
        if (pick >= 0 && cnt < NS) begin
            n_st[pick] = 1;
            n_tk[pick] = m_tail;
            m_tail = (m_tail + 1) % NS;
            order_q.push_back(pick);
        end
        m_ovf = anycand && (cnt == NS);
        m_pro = bad;
        m_serve = n_serve;
        for (int i = 0; i < NR; i++) begin
            m_st[i] = n_st[i];
            m_tk[i] = n_tk[i];
        end
    endtask

    task automatic compare();
        int g;
        g = 0;
        for (int i = 0; i < NR; i++) begin
            if (m_st[i] == 2) g |= (1 << i);
        end
        chk("R6/R4/R5 grant vector", int'(grant), g);
        for (int i = 0; i < NR; i++) chk("R2/R9 ticket", tk_of(i), m_tk[i]);
        chk("R7 overflow_err", int'(overflow_err), int'(m_ovf));
        chk("R8 proto_err", int'(proto_err), int'(m_pro));
    endtask

    // inputs are driven before calling; advances one cycle and compares
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 grant after reset", int'(grant), 0);
        chk("R1 ticket after reset", int'(ticket), 0);
        chk("R1 overflow_err after reset", int'(overflow_err), 0);
        chk("R1 proto_err after reset", int'(proto_err), 0);

        // R1/R4: lone requester 0 takes slot 0
        enter_req = 6'b000001; tick();
        enter_req = '0;
        chk("R4 no grant one cycle after accept", int'(grant[0]), 0);
        tick();
        chk("R4 grant two cycles after accept", int'(grant[0]), 1);
        chk("R1 first ticket is 0", tk_of(0), 0);

        // R3: simultaneous enters served lowest first
        enter_req = 6'b001110; tick();
        chk("R3 only lowest accepted", tk_of(1), 1);
        chk("R3 others unchanged", tk_of(2), 0);
        tick(); tick();
        chk("R3 second ticket", tk_of(2), 2);
        chk("R3 third ticket", tk_of(3), 3);

        // R9: holder re-entering is ignored
        enter_req = 6'b001111; tick();
        chk("R9 owner ticket kept", tk_of(0), 0);
        enter_req = '0;

        // R5: hand-off to next ticket
        exit_req = 6'b000001; tick();
        exit_req = '0;
        chk("R5 released", int'(grant), 0);
        tick();
        chk("R5 next ticket granted", int'(grant), 6'b000010);

        // R8: exit from idle and queued requesters
        exit_req = 6'b100100; tick();
        exit_req = '0;
        chk("R8 proto_err raised", int'(proto_err), 1);
        chk("R8 grant unaffected", int'(grant), 6'b000010);
        tick();
        chk("R8 proto_err clears", int'(proto_err), 0);

        // R7: ring full (1,2,3 outstanding, 4 joins, 5 refused)
        enter_req = 6'b110000; tick();
        chk("R7 fourth ticket wraps", tk_of(4), 0);
        tick();
        chk("R7 overflow_err raised", int'(overflow_err), 1);
        chk("R7 refused ticket", tk_of(5), 0);
        enter_req = '0; tick();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            logic [NR-1:0] en, ex;
            en = '0; ex = '0;
            for (int i = 0; i < NR; i++) begin
                if (m_st[i] == 0 && ($urandom % 2) == 0) en[i] = 1'b1;
                if (m_st[i] == 2 && ($urandom % 3) == 0) ex[i] = 1'b1;
                if (m_st[i] != 2 && ($urandom % 40) == 0) ex[i] = 1'b1;
                if (m_st[i] != 0 && ($urandom % 10) == 0) en[i] = 1'b1;
            end
            enter_req = en;
            exit_req  = ex;
            tick();
        end
        enter_req = '0;
        exit_req  = '0;
        tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule